// File: doc/BRIEF.md
# Serial Gain-Control Port

This block is the digital control side of a programmable-gain line driver. A host writes a gain word over three wires: serial data, serial clock and an active-low load enable. The word goes into a short shift register and lands in a parallel gain latch. The latch changes only when the load enable returns high, so the active gain never moves while a new word is being shifted in. The latched code is decoded into a saturated effective code and a signed gain figure in hundredths of a dB, which the analog section and the firmware can use directly.

The serial lines are slow compared with the system clock. They are oversampled through synchronizers, and the edges are found on the synchronized copies. A separate active-low power-down input selects between the forward output path and the idle reverse path. It acts combinationally and does not depend on the serial port at all.

Top module: `gainctl_serial_port`

## Requirements
- R1: The gain word is sent most significant bit first. The shift register is 7 bits deep, so after an 8-bit word the first bit has fallen out, and the latched 7-bit code equals the low 7 bits of the word (for example, words 0x47 and 0xC7 both give code 71).
- R2: A bit is taken from `sdi` only on a rising edge of `sclk` while `load_n` is low. Changes on `sdi` without an `sclk` rise do not shift. `sclk` pulses while `load_n` is high do not shift.
- R3: While `load_n` is low, `gain_code` keeps its previous value, no matter how many bits are shifted in.
- R4: A low-to-high transition of `load_n` copies the shift register into `gain_code` within three system clock cycles. The shift register keeps its contents until `load_n` goes low again and an `sclk` rise arrives, so a load with no clock pulses transfers the same value again.
- R5: When more than eight clock pulses arrive during one load, shifting continues, and the last 7 bits received form the code.
- R6: `eff_code` equals `gain_code` for codes 0 to 71 and equals 71 for codes 72 to 127.
- R7: `gain_cdb` is the signed value 2600 - round((71 - eff_code) × 75.26), rounded half up. This gives -2743 at code 0, 718 at code 46 and 2600 at code 71.
- R8: `fwd_en` follows `pwr_n` and `rev_en` is its inverse. Both change combinationally, with no system clock edge, and do not depend on the serial inputs.
- R9: A synchronous reset clears both the gain latch and the shift register to code 0, so `gain_cdb` reads -2743 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial gain data, MSB first |
| sclk | input | 1 | Serial clock; a bit is taken on its rising edge |
| load_n | input | 1 | Active-low load enable; its rising edge updates the gain latch |
| pwr_n | input | 1 | Active-low power-down |
| gain_code | output | 7 | Latched gain code |
| eff_code | output | 7 | Code saturated at 71 |
| gain_cdb | output | 16 | Signed gain in units of 0.01 dB |
| fwd_en | output | 1 | Forward output path enable |
| rev_en | output | 1 | Reverse (idle) path enable |

## Verification
A corrupted shift register stays hidden until the next rising edge of `load_n`. It then shows on `gain_code`, `eff_code` and `gain_cdb` together, within three system clocks. For that reason every load is followed by a check of all three outputs. A latch that updates early shows up during a load as a code that moves while `load_n` is still low, so the bench compares the outputs in the middle of a load. A shift that slipped while the port was idle only shows after a later load that has no clock pulses; the bench runs that sequence on purpose.

// File: rtl/gainctl_pkg.sv
package gainctl_pkg;

    localparam int CODE_W   = 7;      // depth of the shift register and latch
    localparam int MAX_CODE = 71;     // highest code that still raises the gain
    localparam int TOP_CDB  = 2600;   // full gain in 0.01 dB
    localparam int STEP_E4  = 7526;   // step size in 0.0001 dB
    localparam int CDB_W    = 16;
    localparam int MIN_CDB  = TOP_CDB - (MAX_CODE * STEP_E4 + 50) / 100;

    typedef logic [CODE_W-1:0]       code_t;
    typedef logic signed [CDB_W-1:0] cdb_t;

    // serial lines packed so the load enable sits in the top bit
    typedef struct packed {
        logic ld;
        logic sck;
        logic sd;
    } serial_t;

    typedef struct packed {
        code_t eff;
        cdb_t  cdb;
    } gain_info_t;

    function automatic code_t saturate(code_t c);
        return (int'(c) > MAX_CODE) ? code_t'(MAX_CODE) : c;
    endfunction

    function automatic cdb_t code_to_cdb(code_t eff);
        int steps;
        int drop;
        steps = MAX_CODE - int'(eff);
        drop  = (steps * STEP_E4 + 50) / 100;
        return cdb_t'(TOP_CDB - drop);
    endfunction

endpackage

// File: rtl/gc_sync.sv
module gc_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/gc_shifter.sv
module gc_shifter
    import gainctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  serial_t ser_i,
    output code_t   latch_o
);
    logic  ld_p, sck_p;
    logic  ld_rise, sck_rise;
    code_t sh_q, latch_q;

    assign ld_rise  = ser_i.ld & ~ld_p;
    assign sck_rise = ser_i.sck & ~sck_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_p    <= 1'b1;
            sck_p   <= 1'b0;
            sh_q    <= '0;
            latch_q <= '0;
        end else begin
            ld_p  <= ser_i.ld;
            sck_p <= ser_i.sck;
            if (sck_rise && !ser_i.ld)
                sh_q <= {sh_q[CODE_W-2:0], ser_i.sd};
            if (ld_rise)
                latch_q <= sh_q;
        end
    end

    assign latch_o = latch_q;

    // R1: new bit enters at the LSB, older bits move up
    p_msb_first_r1: assert property (@(posedge clk) disable iff (rst)
        (sck_rise && !ser_i.ld) |=> (sh_q[0] == $past(ser_i.sd)) &&
                                    (sh_q[CODE_W-1:1] == $past(sh_q[CODE_W-2:0])));

    // R2: no shifting while the enable is high
    p_idle_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        ser_i.ld |=> $stable(sh_q));

    // R3: latch moves only on an enable rise
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !ld_rise |=> $stable(latch_q));

    // R4: enable rise copies the shift register
    p_transfer_r4: assert property (@(posedge clk) disable iff (rst)
        ld_rise |=> latch_q == $past(sh_q));
endmodule

// File: rtl/gc_decode.sv
module gc_decode
    import gainctl_pkg::*;
(
    input  code_t      code_i,
    output gain_info_t info_o
);
    always_comb begin
        info_o.eff = saturate(code_i);
        info_o.cdb = code_to_cdb(info_o.eff);
    end

    always_comb begin
        if (!$isunknown(code_i)) begin
            p_sat_r6: assert (int'(info_o.eff) <= MAX_CODE &&
                              (int'(code_i) > MAX_CODE || info_o.eff == code_i));
            p_span_r7: assert (int'(info_o.cdb) >= MIN_CDB && int'(info_o.cdb) <= TOP_CDB);
        end
    end
endmodule

// File: rtl/gainctl_serial_port.sv
module gainctl_serial_port
    import gainctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sdi,
    input  logic                    sclk,
    input  logic                    load_n,
    input  logic                    pwr_n,
    output logic [CODE_W-1:0]       gain_code,
    output logic [CODE_W-1:0]       eff_code,
    output logic signed [CDB_W-1:0] gain_cdb,
    output logic                    fwd_en,
    output logic                    rev_en
);
    localparam int SER_W = $bits(serial_t);

    serial_t    raw, synced;
    code_t      latch;
    gain_info_t info;

    assign raw = '{ld: load_n, sck: sclk, sd: sdi};

    gc_sync #(
        .W       (SER_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SER_W'(3'b100))
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    gc_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .ser_i   (synced),
        .latch_o (latch)
    );

    gc_decode u_dec (
        .code_i (latch),
        .info_o (info)
    );

    assign gain_code = latch;
    assign eff_code  = info.eff;
    assign gain_cdb  = info.cdb;

    // power-down path bypasses all clocked logic
    assign fwd_en = pwr_n;
    assign rev_en = ~pwr_n;

    // R9: reset leaves minimum gain
    p_reset_min_r9: assert property (@(posedge clk)
        rst |=> gain_code == '0);
endmodule

// File: tb/gainctl_serial_port_tb.sv
`timescale 1ns/1ps
module gainctl_serial_port_tb;
    logic clk = 0, rst = 1;
    logic sdi = 0, sclk = 0, load_n = 1, pwr_n = 1;
    logic [6:0] gain_code, eff_code;
    logic signed [15:0] gain_cdb;
    logic fwd_en, rev_en;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [6:0] m_sh = 0, m_latch = 0;

    always #2.5 clk = ~clk;

    gainctl_serial_port u_dut (
        .clk(clk), .rst(rst), .sdi(sdi), .sclk(sclk), .load_n(load_n), .pwr_n(pwr_n),
        .gain_code(gain_code), .eff_code(eff_code), .gain_cdb(gain_cdb),
        .fwd_en(fwd_en), .rev_en(rev_en)
    );

    function automatic int exp_eff(int c);
        return (c > 71) ? 71 : c;
    endfunction

    function automatic int exp_cdb(int c);
        int k, whole, frac;
        k = 71 - exp_eff(c);
        whole = k * 75 + (k * 26) / 100;
        frac  = (k * 26) % 100;
        if (frac >= 50) whole++;
        return 2600 - whole;
    endfunction

    task automatic chk(string req, int got, int expv);
        checks++;
        if (got != expv) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_gain(string req);
        chk({req, " code"}, int'(gain_code), int'(m_latch));
        chk({req, " eff"},  int'(eff_code), exp_eff(int'(m_latch)));
        chk({req, " cdb"},  int'(gain_cdb), exp_cdb(int'(m_latch)));
    endtask

    task automatic pulse_bit(logic b);
        sdi = b; cyc(3);
        sclk = 1; cyc(3);
        sclk = 0;
        if (!load_n) m_sh = {m_sh[5:0], b};
    endtask

    task automatic begin_load();
        load_n = 0; cyc(3);
    endtask

    task automatic end_load();
        cyc(3); load_n = 1; cyc(6);
        m_latch = m_sh;
    endtask

    task automatic send(logic [15:0] w, int n);
        begin_load();
        for (int i = n - 1; i >= 0; i--) pulse_bit(w[i]);
        end_load();
    endtask

    task automatic check_pwr(string req);
        #1;
        chk({req, " fwd"}, int'(fwd_en), int'(pwr_n));
        chk({req, " rev"}, int'(rev_en), int'(!pwr_n));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        cyc(4); rst = 0; cyc(2);
        // R9 reset state
        check_gain("R9 reset");
        chk("R9 reset cdb", int'(gain_cdb), -2743);
        check_pwr("R8 reset");

        send(16'h47, 8); check_gain("R1 code71");
        chk("R7 full", int'(gain_cdb), 2600);
        send(16'hC7, 8); check_gain("R1 msb ignored");
        chk("R1 msb ignored", int'(gain_code), 71);
        send(16'h48, 8); check_gain("R6 code72");
        chk("R6 sat", int'(eff_code), 71);
        send(16'h7F, 8); check_gain("R6 code127");
        send(16'h2E, 8); check_gain("R7 half step");
        chk("R7 half step", int'(gain_cdb), 718);
        send(16'h00, 8); check_gain("R7 zero");

        // R3: latch holds during a load
        send(16'h15, 8);
        begin_load();
        for (int i = 7; i >= 0; i--) pulse_bit(8'hB3 >> i);
        cyc(6); check_gain("R3 mid-load");
        chk("R3 mid-load", int'(gain_code), 8'h15);
        end_load(); check_gain("R3 after");

        // R2: sdi wiggles without sclk do not shift
        begin_load();
        for (int i = 0; i < 6; i++) begin sdi = i[0]; cyc(3); end
        end_load(); check_gain("R2 no clock");

        // R4/R2: clocks while idle ignored, empty load re-transfers
        for (int i = 0; i < 5; i++) pulse_bit(1'b1);
        send(16'h0, 0); check_gain("R4 empty load");
        chk("R4 empty load", int'(gain_code), 8'hB3 & 8'h7F);

        // R5: extra pulses keep the last 7 bits
        send(16'h5A5, 11); check_gain("R5 eleven");
        chk("R5 eleven", int'(gain_code), 16'h5A5 & 16'h7F);

        // R8: power-down independent of serial activity
        pwr_n = 0; check_pwr("R8 down");
        begin_load(); pulse_bit(1); check_pwr("R8 during load");
        pwr_n = 1; check_pwr("R8 up");
        for (int i = 0; i < 6; i++) pulse_bit(i[1]);
        end_load(); check_gain("R8 gain kept");

        // random loads
        for (int it = 0; it < 40; it++) begin
            int n;
            logic [15:0] w;
            n = 7 + int'($urandom % 4);
            w = 16'($urandom);
            if (($urandom % 4) == 0) begin
                pwr_n = ~pwr_n; check_pwr("R8 random");
            end
            send(w, n); check_gain("R1 R5 random");
        end

        // R9 reset mid-run clears shift register too
        begin_load(); pulse_bit(1); pulse_bit(1);
        @(negedge clk); rst = 1; cyc(3); rst = 0; load_n = 1; cyc(6);
        m_sh = 0; m_latch = 0;
        check_gain("R9 mid reset");
        send(16'h0, 0); check_gain("R9 shift cleared");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule